// File: doc/BRIEF.md
# Narrowing Saturating Right Shifter

This unit takes a 128-bit source vector of double-width lanes, shifts every lane right by an immediate amount, and narrows each result to half width. Rounding can be applied before the shift. When saturation is enabled, each narrowed value is clamped to the range of the destination lane. The source and the destination can each be signed or unsigned, and the two choices are made independently. When saturation is off, the unit performs a plain truncating narrow.

The narrowed lanes form one 64-bit half. That half is written into either the lower or the upper half of the 128-bit destination. In upper-half mode, the lower half of the existing destination value passes through unchanged. In scalar mode, only lane 0 is produced. A pipeline stage issues one operation per `inValid` pulse and returns the finished destination vector one cycle later. The stage also reports whether this operation clamped any lane, and it keeps a sticky clamp flag.

Top module: `nsr_top`

## Requirements
- R1: `sizeCode` n = 0, 1 or 2 selects destination lanes of w = 8<<n bits and source lanes of 2w bits, giving 8>>n lanes. Source lane i is `srcVec[i*2w +: 2w]` and result lane i sits at bits `[i*w +: w]` of the narrowed half. Code 3 behaves as code 2.
- R2: The shift actually applied is `shiftAmt` clipped into the range 1 to w. A value of 0 shifts by 1, and any value above w shifts by w.
- R3: With `roundEn` high, 2^(s-1) is added to the extended source lane before the shift by s. The sum is formed wide enough that a carry out of the source width is kept.
- R4: With `satEn` low, the source is treated as unsigned, the shift is logical, and the low w bits are kept. `srcSigned` and `dstSigned` have no effect, and `satNow` stays 0.
- R5: With `satEn`, `srcSigned` and `dstSigned` all high, the source is sign-extended and shifted arithmetically, and the result is clamped to [-2^(w-1), 2^(w-1)-1].
- R6: With `satEn` and `srcSigned` high and `dstSigned` low, the shift is arithmetic and the result is clamped to [0, 2^w-1]. A negative value therefore becomes 0.
- R7: With `satEn` high and `srcSigned` low, the shift is logical and the result is clamped to [0, 2^w-1]. `dstSigned` has no effect.
- R8: Lower-half mode (`upperHalf`=0, `scalarMode`=0) places the narrowed half in bits 63:0 and clears bits 127:64.
- R9: Upper-half mode (`upperHalf`=1, `scalarMode`=0) places the narrowed half in bits 127:64 and copies bits 63:0 from `dstVec`.
- R10: In scalar mode, only lane 0 is produced, at bits w-1:0, and every other output bit is 0. `upperHalf` has no effect, and only lane 0 can raise `satNow`.
- R11: The result, `satNow` and a one-cycle `outValid` pulse appear on the clock edge that samples `inValid` high. While `inValid` is low, `resultVec` and `satNow` hold their values.
- R12: `satNow` is 1 when any computed lane of the latest operation was clamped. `satSticky` sets together with it and stays set until reset.
- R13: After reset, `outValid`, `resultVec`, `satNow` and `satSticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Issues an operation this cycle |
| srcVec | input | 128 | Source vector of double-width lanes |
| dstVec | input | 128 | Current destination value (lower half kept in upper-half mode) |
| sizeCode | input | 2 | Destination lane size code |
| shiftAmt | input | 6 | Right shift immediate |
| roundEn | input | 1 | Add rounding constant before shifting |
| satEn | input | 1 | Saturating narrow instead of truncating narrow |
| srcSigned | input | 1 | Source lanes are signed (saturating mode only) |
| dstSigned | input | 1 | Destination range is signed (signed source only) |
| upperHalf | input | 1 | Write results into bits 127:64 |
| scalarMode | input | 1 | Produce lane 0 only |
| outValid | output | 1 | Result valid pulse |
| resultVec | output | 128 | Updated destination vector |
| satNow | output | 1 | Latest operation clamped at least one lane |
| satSticky | output | 1 | Some operation since reset clamped |

## Verification
The checker watches five properties on every cycle:
- the one-cycle issue-to-result timing;
- that the result and `satNow` hold while idle;
- that the upper half is cleared in lower-half and scalar modes;
- that the lower half of `dstVec` passes through in upper-half mode;
- that `satSticky` never falls and that `satNow` stays low whenever saturation is off.

The lane arithmetic itself can only be shown by the bench's scenarios. This covers the rounding carry, the clamp points for each of the three signedness combinations, and the clipping of the shift amount. The bench sweeps every lane size, a set of shift values around each lane width, all flag combinations and all three placement modes against its own arithmetic model.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int BASE_W    = 8;                  // narrowest destination lane
  localparam int NUM_SIZES = 3;                  // 8, 16, 32-bit destination lanes
  localparam int LANES_MAX = HALF_W / BASE_W;
  localparam int SIZE_W    = 2;
  localparam int SHIFT_W   = 6;

  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeHot;   // one-hot lane size
    logic [SHIFT_W-1:0]   shiftEff;  // clipped shift, 1..w
    logic                 srcSx;     // sign-extend source
    logic                 dstSx;     // signed clamp range
    logic                 satOn;
    logic                 rndOn;
    logic                 toUpper;
    logic                 scalarOn;
    logic                 capture;
  } ctrl_t;
endpackage

// File: rtl/nsr_lane.sv
module nsr_lane #(
  parameter int W = 8
) (
  input  logic [2*W-1:0]               srcLane,
  input  logic [nsr_pkg::SHIFT_W-1:0]  shiftEff,
  input  logic                         srcSx,
  input  logic                         dstSx,
  input  logic                         satOn,
  input  logic                         rndOn,
  output logic [W-1:0]                 laneOut,
  output logic                         laneSat
);
  localparam int SW = 2 * W;
  localparam int XW = SW + 2;  // sign plus carry headroom
  localparam logic signed [XW-1:0] S_MAX = XW'((64'd1 << (W - 1)) - 64'd1);
  localparam logic signed [XW-1:0] S_MIN = ~S_MAX;
  localparam logic signed [XW-1:0] U_MAX = XW'((64'd1 << W) - 64'd1);

  logic [XW-1:0]        extVal;
  logic [XW-1:0]        rndVal;
  logic [XW-1:0]        sumVal;
  logic signed [XW-1:0] shifted;

  always_comb begin
    extVal  = srcSx ? {{2{srcLane[SW-1]}}, srcLane} : {2'b00, srcLane};
    rndVal  = rndOn ? (XW'(1) << (shiftEff - 1'b1)) : '0;
    sumVal  = extVal + rndVal;
    shifted = $signed(sumVal) >>> shiftEff;
    laneSat = 1'b0;
    laneOut = shifted[W-1:0];
    if (satOn) begin
      if (dstSx) begin
        if (shifted > S_MAX) begin
          laneOut = S_MAX[W-1:0];
          laneSat = 1'b1;
        end else if (shifted < S_MIN) begin
          laneOut = S_MIN[W-1:0];
          laneSat = 1'b1;
        end
      end else begin
        if (shifted[XW-1]) begin
          laneOut = '0;
          laneSat = 1'b1;
        end else if (shifted > U_MAX) begin
          laneOut = '1;
          laneSat = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nsr_ctrl.sv
module nsr_ctrl
  import nsr_pkg::*;
(
  input  logic               inValid,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               roundEn,
  input  logic               satEn,
  input  logic               srcSigned,
  input  logic               dstSigned,
  input  logic               upperHalf,
  input  logic               scalarMode,
  output ctrl_t              ctrl
);
  logic [SIZE_W-1:0]  sizeEff;
  logic [SHIFT_W:0]   laneW;

  always_comb begin
    sizeEff = sizeCode;
    if (int'(sizeCode) >= NUM_SIZES) sizeEff = SIZE_W'(NUM_SIZES - 1);
    laneW = (SHIFT_W + 1)'(BASE_W) << sizeEff;

    ctrl = '0;
    ctrl.sizeHot = NUM_SIZES'(1) << sizeEff;
    if (shiftAmt == '0)                 ctrl.shiftEff = SHIFT_W'(1);
    else if ({1'b0, shiftAmt} > laneW)  ctrl.shiftEff = laneW[SHIFT_W-1:0];
    else                                ctrl.shiftEff = shiftAmt;
    ctrl.satOn    = satEn;
    ctrl.srcSx    = satEn & srcSigned;
    ctrl.dstSx    = satEn & srcSigned & dstSigned;
    ctrl.rndOn    = roundEn;
    ctrl.scalarOn = scalarMode;
    ctrl.toUpper  = upperHalf & ~scalarMode;
    ctrl.capture  = inValid;
  end
endmodule

// File: rtl/nsr_datapath.sv
module nsr_datapath
  import nsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstVec,
  output logic             outValid,
  output logic [VEC_W-1:0] resultVec,
  output logic             satNow,
  output logic             satSticky
);
  logic [NUM_SIZES-1:0][HALF_W-1:0]    packG;
  logic [NUM_SIZES-1:0][LANES_MAX-1:0] satG;
  logic [NUM_SIZES-1:0][HALF_W-1:0]    lane0MaskG;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int DW = BASE_W << g;
    localparam int NL = HALF_W / DW;
    assign lane0MaskG[g] = {{(HALF_W - DW){1'b0}}, {DW{1'b1}}};
    for (genvar l = 0; l < LANES_MAX; l++) begin : g_lane
      if (l < NL) begin : g_live
        nsr_lane #(.W(DW)) u_lane (
          .srcLane (srcVec[l*2*DW +: 2*DW]),
          .shiftEff(ctrl.shiftEff),
          .srcSx   (ctrl.srcSx),
          .dstSx   (ctrl.dstSx),
          .satOn   (ctrl.satOn),
          .rndOn   (ctrl.rndOn),
          .laneOut (packG[g][l*DW +: DW]),
          .laneSat (satG[g][l])
        );
      end else begin : g_idle
        assign satG[g][l] = 1'b0;
      end
    end
  end

  logic [HALF_W-1:0]    narrowSel;
  logic [HALF_W-1:0]    lane0Mask;
  logic [LANES_MAX-1:0] satSel;
  logic [VEC_W-1:0]     nextVec;
  logic                 satNext;

  always_comb begin
    narrowSel = '0;
    lane0Mask = '0;
    satSel    = '0;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (ctrl.sizeHot[g]) begin
        narrowSel = packG[g];
        lane0Mask = lane0MaskG[g];
        satSel    = satG[g];
      end
    end
    if (ctrl.scalarOn) begin
      nextVec = {{HALF_W{1'b0}}, narrowSel & lane0Mask};
      satNext = satSel[0];
    end else begin
      nextVec = ctrl.toUpper ? {narrowSel, dstVec[HALF_W-1:0]}
                             : {{HALF_W{1'b0}}, narrowSel};
      satNext = |satSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      resultVec <= '0;
      satNow    <= 1'b0;
      satSticky <= 1'b0;
    end else begin
      outValid <= ctrl.capture;
      if (ctrl.capture) begin
        resultVec <= nextVec;
        satNow    <= satNext;
        satSticky <= satSticky | satNext;
      end
    end
  end
endmodule

// File: rtl/nsr_top.sv
module nsr_top
  import nsr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [VEC_W-1:0]   srcVec,
  input  logic [VEC_W-1:0]   dstVec,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               roundEn,
  input  logic               satEn,
  input  logic               srcSigned,
  input  logic               dstSigned,
  input  logic               upperHalf,
  input  logic               scalarMode,
  output logic               outValid,
  output logic [VEC_W-1:0]   resultVec,
  output logic               satNow,
  output logic               satSticky
);
  ctrl_t ctrl;

  nsr_ctrl u_ctrl (
    .inValid   (inValid),
    .sizeCode  (sizeCode),
    .shiftAmt  (shiftAmt),
    .roundEn   (roundEn),
    .satEn     (satEn),
    .srcSigned (srcSigned),
    .dstSigned (dstSigned),
    .upperHalf (upperHalf),
    .scalarMode(scalarMode),
    .ctrl      (ctrl)
  );

  nsr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .srcVec   (srcVec),
    .dstVec   (dstVec),
    .outValid (outValid),
    .resultVec(resultVec),
    .satNow   (satNow),
    .satSticky(satSticky)
  );
endmodule

// File: rtl/nsr_checker.sv
module nsr_checker
  import nsr_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [VEC_W-1:0]   srcVec,
  input logic [VEC_W-1:0]   dstVec,
  input logic [SIZE_W-1:0]  sizeCode,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic               roundEn,
  input logic               satEn,
  input logic               srcSigned,
  input logic               dstSigned,
  input logic               upperHalf,
  input logic               scalarMode,
  input logic               outValid,
  input logic [VEC_W-1:0]   resultVec,
  input logic               satNow,
  input logic               satSticky
);
  // R11: one-cycle issue-to-result pulse
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R11: idle cycles hold the result
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resultVec) && $stable(satNow)));
  // R8 and R10: upper half cleared
  assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (!upperHalf || scalarMode)) |=> (resultVec[VEC_W-1:HALF_W] == '0));
  // R9: lower half of destination kept
  assert_lower_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && upperHalf && !scalarMode) |=> (resultVec[HALF_W-1:0] == $past(dstVec[HALF_W-1:0])));
  // R10: scalar mode leaves only lane 0 bits
  assert_scalar_lane0_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && scalarMode && sizeCode == 2'd0) |=> (resultVec[VEC_W-1:8] == '0));
  // R4: truncating narrow never reports a clamp
  assert_no_sat_trunc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !satEn) |=> !satNow);
  // R12: sticky flag never falls and covers satNow
  assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    satSticky |=> satSticky);
  assert_sticky_cover_R12: assert property (@(posedge clk) disable iff (!rstN)
    satNow |-> satSticky);
endmodule

bind nsr_top nsr_checker u_chk (.*);

// File: tb/tb_nsr_top.sv
module tb_nsr_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [127:0] dstVec = '0;
  logic [1:0]   sizeCode = '0;
  logic [5:0]   shiftAmt = '0;
  logic         roundEn = 1'b0, satEn = 1'b0, srcSigned = 1'b0, dstSigned = 1'b0;
  logic         upperHalf = 1'b0, scalarMode = 1'b0;
  logic         outValid;
  logic [127:0] resultVec;
  logic         satNow, satSticky;

  int checks = 0;
  int errors = 0;
  logic stickyExp = 1'b0;
  logic [31:0] prng = 32'h1234_5678;

  always #4 clk = ~clk;

  nsr_top dut (.*);

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Arithmetic model of the requirements
  task automatic model(input logic [127:0] src, input logic [127:0] dst,
                       input int sz0, input int sh0, input logic rnd, input logic sat,
                       input logic ss, input logic ds, input logic up, input logic sc,
                       output logic [127:0] vecOut, output logic satOut);
    int sz, w, nl, s;
    logic [127:0] packed64;
    logic [71:0] raw;
    logic signed [71:0] v, smax, smin, umax;
    logic sx, dsx;
    sz = (sz0 > 2) ? 2 : sz0;
    w  = 8 << sz;
    nl = 64 / w;
    s  = (sh0 == 0) ? 1 : ((sh0 > w) ? w : sh0);
    sx  = sat && ss;
    dsx = sat && ss && ds;
    smax = $signed((72'd1 << (w - 1)) - 72'd1);
    smin = -smax - 72'sd1;
    umax = $signed((72'd1 << w) - 72'd1);
    packed64 = '0;
    satOut = 1'b0;
    for (int i = 0; i < (sc ? 1 : nl); i++) begin
      raw = 72'(src >> (i * 2 * w)) & ((72'd1 << (2 * w)) - 72'd1);
      if (sx && raw[2*w-1]) v = $signed(raw) - $signed(72'd1 << (2 * w));
      else v = $signed(raw);
      if (rnd) v = v + $signed(72'd1 << (s - 1));
      v = v >>> s;
      if (sat) begin
        if (dsx) begin
          if (v > smax) begin v = smax; satOut = 1'b1; end
          else if (v < smin) begin v = smin; satOut = 1'b1; end
        end else begin
          if (v < 0) begin v = '0; satOut = 1'b1; end
          else if (v > umax) begin v = umax; satOut = 1'b1; end
        end
      end
      packed64 = packed64 | (128'(72'(v) & ((72'd1 << w) - 72'd1)) << (i * w));
    end
    if (sc || !up) vecOut = {64'd0, packed64[63:0]};
    else vecOut = {packed64[63:0], dst[63:0]};
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    stickyExp = 1'b0;
    @(negedge clk);
  endtask

  task automatic doOp(input logic [127:0] src, input logic [127:0] dst, input int sz,
                      input int sh, input logic [3:0] f, input int mode, input string tag);
    logic [127:0] expVec;
    logic expSat;
    string req;
    @(negedge clk);
    srcVec = src; dstVec = dst; sizeCode = 2'(sz); shiftAmt = 6'(sh);
    roundEn = f[0]; satEn = f[1]; srcSigned = f[2]; dstSigned = f[3];
    upperHalf = (mode == 1); scalarMode = (mode == 2);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    model(src, dst, sz, sh, f[0], f[1], f[2], f[3], mode == 1, mode == 2, expVec, expSat);
    stickyExp = stickyExp | expSat;
    // R1 lane geometry, R2 shift clipping, R3 rounding are all covered by this compare
    if (!f[1]) req = "R4";
    else if (f[2] && f[3]) req = "R5";
    else if (f[2]) req = "R6";
    else req = "R7";
    req = $sformatf("%s %s %s R1 R2 R3", tag, req, (mode == 0) ? "R8" : ((mode == 1) ? "R9" : "R10"));
    check(resultVec == expVec, req, resultVec, expVec);
    check(satNow == expSat, "R12 satNow", 128'(satNow), 128'(expSat));
    check(satSticky == stickyExp, "R12 satSticky", 128'(satSticky), 128'(stickyExp));
    check(outValid == 1'b1, "R11 outValid", 128'(outValid), 128'd1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    int shifts[14] = '{0, 1, 2, 3, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63};
    repeat (2) @(negedge clk);
    // R13: reset state
    check(outValid == 1'b0 && satNow == 1'b0 && satSticky == 1'b0, "R13 flags",
          128'({outValid, satNow, satSticky}), 128'd0);
    check(resultVec == '0, "R13 resultVec", resultVec, 128'd0);
    doReset();

    // R3: rounding carry kept; unsigned 0xFFFF +1 >> 1 = 0x8000, truncates to 0x00
    doOp(128'h0000_FFFF, '1, 0, 1, 4'b0001, 0, "R3 carry");
    check(resultVec[7:0] == 8'h00, "R3 truncated carry", 128'(resultVec[7:0]), 128'd0);
    check(satSticky == 1'b0, "R12 sticky clear", 128'(satSticky), 128'd0);
    // R7: same with unsigned saturation clamps to 0xFF
    doOp(128'h0000_FFFF, '1, 0, 1, 4'b0011, 0, "R7 carry clamp");
    check(resultVec[7:0] == 8'hFF && satNow, "R7 clamp 0xFF", 128'(resultVec[7:0]), 128'hFF);
    // R12: sticky stays after a clean op
    doOp(128'h0, '0, 1, 4, 4'b0010, 0, "R12 clean");
    check(satNow == 1'b0 && satSticky == 1'b1, "R12 sticky held",
          128'({satNow, satSticky}), 128'b01);

    // R11: idle cycles hold the result while inputs change
    held = resultVec;
    @(negedge clk);
    srcVec = '1; dstVec = '1; satEn = 1'b1; shiftAmt = 6'd5;
    repeat (3) @(negedge clk);
    check(resultVec == held && outValid == 1'b0, "R11 hold", resultVec, held);

    // Sweep: patterns x sizes x shifts x flags x modes
    doReset();
    for (int p = 0; p < 4; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int si = 0; si < 14; si++) begin
          for (int f = 0; f < 16; f++) begin
            for (int m = 0; m < 3; m++) begin
              logic [127:0] src, dst;
              prng = nextRand(prng); src[31:0]   = prng;
              prng = nextRand(prng); src[63:32]  = prng;
              prng = nextRand(prng); src[95:64]  = prng;
              prng = nextRand(prng); src[127:96] = prng;
              prng = nextRand(prng); dst = {4{prng}};
              case (p)
                1: src = '1;
                2: src = {16{8'h80}};
                3: src = {16{8'h7F}};
                default: ;
              endcase
              doOp(src, dst, sz, shifts[si], 4'(f), m, "sweep");
            end
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule